// File: doc/BRIEF.md
# Wake-up input detector

This block watches a set of local wake-up pins. Two pins are provided by default. Each pin has its own control field that chooses which edges count as a wake event: rising, falling, both, or none. A second per-pin bit chooses when the pin is read. The pin can be read on every clock, or only once per cycle of a periodic bias window that the block generates for externally biased switches. The bias window repeats with one of two periods, and a single control bit picks which one. A millisecond tick comes from a parameterised prescaler, so short periods can be used in simulation.

When an enabled pin shows a valid edge, the block acts on the current system mode. In standby or normal mode it raises a one-cycle interrupt request for that pin. In sleep mode it raises a one-cycle request to move to standby. The block also reports the last level it sampled on each pin. That report is gated, so it only shows levels while at least one pin has wake detection enabled. The mode state machine and the register file sit outside this block. There is no data stream here: every port is a plain control or status signal that is valid on each clock.

Top module: `wkup_sense`

## Requirements
- R1: The 2-bit edge select of each pin (bits [2i+1:2i] of `edge_sel_i`) is decoded as follows. 01 reacts to rising edges only, 10 to falling edges only, and 11 to both.
- R2: An edge select of 00 disables the pin. Edges on that pin produce no interrupt and no standby request.
- R3: In continuous mode (`sync_en_i[i]`=0), a pin change applied between clock edges gives a one-cycle `wake_irq_o[i]` pulse after the third following rising edge. This happens when `sys_mode_i` is 01 (standby) or 10 (normal).
- R4: With `sys_mode_i` = 00 (sleep), a wake event pulses `stby_req_o` for one cycle with the same latency and raises no interrupt. With `sys_mode_i` = 11 (protected), a wake event has no effect.
- R5: `level_o` reads all zeros whenever every edge select is 00. Otherwise bit i shows the most recently sampled level of pin i.
- R6: In sync mode (`sync_en_i[i]`=1), a pin is sampled only at the end of the bias window. Its level and events do not change between samples, and an event's interrupt is high in the first cycle after `bias_en_o` falls.
- R7: `bias_en_o` repeats every SHORT_MS×TICKS_PER_MS cycles when `long_period_i`=0 and every LONG_MS×TICKS_PER_MS cycles when it is 1. Each time, it is high for SETTLE_MS×TICKS_PER_MS cycles, ending at the sample point.
- R8: The first sample of a pin after reset only sets the reference level and never produces an event, whatever the pin level.
- R9: During and right after reset, `wake_irq_o`, `stby_req_o`, `level_o` and `bias_en_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wake_pin_i | input | NPINS | Asynchronous wake pins |
| edge_sel_i | input | 2*NPINS | Per-pin edge select (00 off, 01 rise, 10 fall, 11 both) |
| sync_en_i | input | NPINS | Per-pin: 1 = sample at bias window end, 0 = every clock |
| long_period_i | input | 1 | Bias period select: 0 short, 1 long |
| sys_mode_i | input | 2 | System mode: 00 sleep, 01 standby, 10 normal, 11 protected |
| bias_en_o | output | 1 | Periodic bias enable for external switches |
| wake_irq_o | output | NPINS | One-cycle wake interrupt request per pin |
| stby_req_o | output | 1 | One-cycle request to leave sleep for standby |
| level_o | output | NPINS | Gated latched pin levels |

## Verification
The bench builds the block with TICKS_PER_MS=4, SHORT_MS=4, LONG_MS=8 and SETTLE_MS=1. With these values the bias period is 16 or 32 clocks and the window is 4 clocks wide. Many sync-mode sample points therefore fit into a short run, and both period settings can be measured exactly. The bench also checks that a sync-mode edge stays invisible until the window closes.

// File: rtl/wk_pkg.sv
package wk_pkg;
  typedef enum logic [1:0] {
    MODE_SLEEP = 2'b00,
    MODE_STBY  = 2'b01,
    MODE_NORM  = 2'b10,
    MODE_PROT  = 2'b11
  } sysmode_t;

  localparam logic [1:0] EDGE_OFF  = 2'b00;
  localparam logic [1:0] EDGE_RISE = 2'b01;
  localparam logic [1:0] EDGE_FALL = 2'b10;
  localparam logic [1:0] EDGE_BOTH = 2'b11;

  function automatic logic edge_hit(input logic [1:0] sel, input logic old_v, input logic new_v);
    logic rise;
    logic fall;
    rise = !old_v && new_v;
    fall = old_v && !new_v;
    case (sel)
      EDGE_RISE: edge_hit = rise;
      EDGE_FALL: edge_hit = fall;
      EDGE_BOTH: edge_hit = rise || fall;
      default:   edge_hit = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/wk_bias_gen.sv
module wk_bias_gen #(
  parameter int TICKS_PER_MS = 1000,
  parameter int SHORT_MS     = 16,
  parameter int LONG_MS      = 64,
  parameter int SETTLE_MS    = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic long_i,
  output logic bias_o,
  output logic strobe_o
);
  localparam int TW = (TICKS_PER_MS > 1) ? $clog2(TICKS_PER_MS) : 1;
  localparam int MW = $clog2(LONG_MS + 1);

  logic [TW-1:0] pre_cnt;
  logic [MW-1:0] ms_cnt;
  logic          ms_tick;
  logic [MW-1:0] last_ms;
  logic [MW-1:0] open_ms;

  assign ms_tick = (pre_cnt == TW'(TICKS_PER_MS - 1));
  assign last_ms = long_i ? MW'(LONG_MS - 1) : MW'(SHORT_MS - 1);
  assign open_ms = long_i ? MW'(LONG_MS - SETTLE_MS) : MW'(SHORT_MS - SETTLE_MS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
    end else if (ms_tick) begin
      pre_cnt <= '0;
    end else begin
      pre_cnt <= pre_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ms_cnt <= '0;
    end else if (ms_tick) begin
      if (ms_cnt >= last_ms) ms_cnt <= '0;
      else                   ms_cnt <= ms_cnt + 1'b1;
    end
  end

  // Window opens SETTLE_MS ticks before the wrap and closes at the wrap.
  assign bias_o   = (ms_cnt >= open_ms);
  assign strobe_o = ms_tick && (ms_cnt >= last_ms);
endmodule

// File: rtl/wk_pin_chan.sv
module wk_pin_chan
  import wk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_i,
  input  logic [1:0] edge_sel_i,
  input  logic       sync_en_i,
  input  logic       strobe_i,
  output logic       event_o,
  output logic       level_o
);
  logic s1, s2;
  logic v1, v2;
  logic ref_lvl;
  logic armed;
  logic take;

  // Two-flop synchroniser with a fill marker so reset values are never sampled.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      v1 <= 1'b0;
      v2 <= 1'b0;
    end else begin
      s1 <= pin_i;
      s2 <= s1;
      v1 <= 1'b1;
      v2 <= v1;
    end
  end

  assign take = v2 && (sync_en_i ? strobe_i : 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_lvl <= 1'b0;
      armed   <= 1'b0;
    end else if (take) begin
      ref_lvl <= s2;
      armed   <= 1'b1;
    end
  end

  assign event_o = take && armed && edge_hit(edge_sel_i, ref_lvl, s2);
  assign level_o = ref_lvl;
endmodule

// File: rtl/wk_route.sv
module wk_route
  import wk_pkg::*;
#(
  parameter int NPINS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] event_i,
  input  logic [1:0]       mode_i,
  output logic [NPINS-1:0] irq_o,
  output logic             stby_o
);
  sysmode_t mode;
  logic     awake;
  logic     asleep;

  assign mode   = sysmode_t'(mode_i);
  assign awake  = (mode == MODE_STBY) || (mode == MODE_NORM);
  assign asleep = (mode == MODE_SLEEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_o  <= '0;
      stby_o <= 1'b0;
    end else begin
      irq_o  <= awake ? event_i : '0;
      stby_o <= asleep && (|event_i);
    end
  end
endmodule

// File: rtl/wkup_sense.sv
module wkup_sense #(
  parameter int NPINS        = 2,
  parameter int TICKS_PER_MS = 1000,
  parameter int SHORT_MS     = 16,
  parameter int LONG_MS      = 64,
  parameter int SETTLE_MS    = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NPINS-1:0]   wake_pin_i,
  input  logic [2*NPINS-1:0] edge_sel_i,
  input  logic [NPINS-1:0]   sync_en_i,
  input  logic               long_period_i,
  input  logic [1:0]         sys_mode_i,
  output logic               bias_en_o,
  output logic [NPINS-1:0]   wake_irq_o,
  output logic               stby_req_o,
  output logic [NPINS-1:0]   level_o
);
  logic             strobe;
  logic [NPINS-1:0] evt;
  logic [NPINS-1:0] lvl;
  logic             any_en;

  wk_bias_gen #(
    .TICKS_PER_MS(TICKS_PER_MS),
    .SHORT_MS    (SHORT_MS),
    .LONG_MS     (LONG_MS),
    .SETTLE_MS   (SETTLE_MS)
  ) u_bias (
    .clk     (clk),
    .rst_n   (rst_n),
    .long_i  (long_period_i),
    .bias_o  (bias_en_o),
    .strobe_o(strobe)
  );

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    wk_pin_chan u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin_i     (wake_pin_i[i]),
      .edge_sel_i(edge_sel_i[2*i +: 2]),
      .sync_en_i (sync_en_i[i]),
      .strobe_i  (strobe),
      .event_o   (evt[i]),
      .level_o   (lvl[i])
    );
  end

  wk_route #(.NPINS(NPINS)) u_route (
    .clk    (clk),
    .rst_n  (rst_n),
    .event_i(evt),
    .mode_i (sys_mode_i),
    .irq_o  (wake_irq_o),
    .stby_o (stby_req_o)
  );

  assign any_en  = |edge_sel_i;
  assign level_o = any_en ? lvl : '0;
endmodule

// File: rtl/wkup_sense_chk.sv
module wkup_sense_chk #(
  parameter int NPINS = 2,
  parameter int WIN   = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [2*NPINS-1:0] edge_sel_i,
  input logic [NPINS-1:0]   sync_en_i,
  input logic [1:0]         sys_mode_i,
  input logic               bias_en_o,
  input logic [NPINS-1:0]   wake_irq_o,
  input logic               stby_req_o,
  input logic [NPINS-1:0]   level_o
);
  int hi_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         hi_run <= 0;
    else if (bias_en_o) hi_run <= hi_run + 1;
    else                hi_run <= 0;
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_p
    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      wake_irq_o[i] |-> ($past(edge_sel_i[2*i +: 2]) != 2'b00)); // R2
    AST_SYNC_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      (wake_irq_o[i] && sync_en_i[i] && $past(sync_en_i[i])) |-> ($past(bias_en_o) && !bias_en_o)); // R6
  end

  AST_IRQ_AWAKE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (|wake_irq_o) |-> ($past(sys_mode_i) == 2'b01 || $past(sys_mode_i) == 2'b10)); // R3
  AST_STBY_FROM_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    stby_req_o |-> ($past(sys_mode_i) == 2'b00 && wake_irq_o == '0)); // R4
  AST_LEVEL_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_sel_i == '0) |-> (level_o == '0)); // R5
  AST_BIAS_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    bias_en_o |-> (hi_run < WIN)); // R7
endmodule

bind wkup_sense wkup_sense_chk #(
  .NPINS(NPINS),
  .WIN  (SETTLE_MS * TICKS_PER_MS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .edge_sel_i(edge_sel_i),
  .sync_en_i (sync_en_i),
  .sys_mode_i(sys_mode_i),
  .bias_en_o (bias_en_o),
  .wake_irq_o(wake_irq_o),
  .stby_req_o(stby_req_o),
  .level_o   (level_o)
);

// File: tb/wkup_sense_test.sv
module wkup_sense_test;
  localparam int NP = 2;
  localparam int TK = 4;
  localparam int SH = 4;
  localparam int LG = 8;
  localparam int ST = 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] pins = '0;
  logic [3:0]    esel = '0;
  logic [NP-1:0] sync = '0;
  logic          lng = 1'b0;
  logic [1:0]    mode = 2'b01;
  logic          bias;
  logic [NP-1:0] irq;
  logic          stby;
  logic [NP-1:0] lvl;

  int checks = 0;
  int errors = 0;
  string phase = "R9";
  logic b_prev = 1'b0;

  typedef struct {
    int    code;   // 0/1: irq on that pin, 2: standby request
    bit    at_fall;
    string tag;
  } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;

  wkup_sense #(.NPINS(NP), .TICKS_PER_MS(TK), .SHORT_MS(SH), .LONG_MS(LG), .SETTLE_MS(ST)) uut (
    .clk(clk), .rst_n(rst_n), .wake_pin_i(pins), .edge_sel_i(esel), .sync_en_i(sync),
    .long_period_i(lng), .sys_mode_i(mode), .bias_en_o(bias), .wake_irq_o(irq),
    .stby_req_o(stby), .level_o(lvl));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pop_cmp(input int code);
    exp_t e;
    checks++;
    if (q.size() == 0) begin
      errors++;
      $display("FAIL %s unexpected pulse actual=%0d expected=none", phase, code);
    end else begin
      e = q.pop_front();
      if (e.code != code) begin
        errors++;
        $display("FAIL %s actual=%0d expected=%0d", e.tag, code, e.code);
      end
      if (e.at_fall) begin
        checks++;
        if (!(b_prev && !bias)) begin
          errors++;
          $display("FAIL %s bias prev/now actual=%0d%0d expected=10", e.tag, b_prev, bias);
        end
      end
    end
  endtask

  // Monitor: compares produced pulses with the scoreboard queue.
  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < NP; i++) if (irq[i]) pop_cmp(i);
      if (stby) pop_cmp(2);
    end
    b_prev <= bias;
  end

  task automatic push(input int code, input bit f, input string tag);
    exp_t e;
    e.code = code; e.at_fall = f; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drain(input string tag);
    cyc(6);
    chk({tag, " queue empty"}, q.size(), 0);
    q.delete();
  endtask

  task automatic drive(input int p, input logic v, input int code, input string tag);
    phase = tag;
    if (code >= 0) push(code, 1'b0, tag);
    @(negedge clk);
    pins[p] = v;
    drain(tag);
  endtask

  task automatic wait_fall();
    do @(negedge clk); while (!(b_prev && !bias));
  endtask

  task automatic wait_rise();
    do @(negedge clk); while (!(!b_prev && bias));
  endtask

  task automatic measure(input string tag, input int per);
    int hi = 0;
    int tot = 0;
    wait_rise();
    do begin @(negedge clk); tot++; if (b_prev) hi++; end while (!(!b_prev && bias));
    chk({tag, " high cycles"}, hi, ST * TK);
    chk({tag, " period"}, tot, per * TK);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cyc(3);
    chk("R9 irq in reset", int'(irq), 0);
    chk("R9 bias in reset", int'(bias), 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R9 stby after reset", int'(stby), 0);
    chk("R9 level after reset", int'(lvl), 0);
    cyc(8);

    // Both pins disabled: edges ignored, levels hidden.
    drive(0, 1'b1, -1, "R2");
    chk("R5 level hidden when all off", int'(lvl), 0);
    @(negedge clk); esel = 4'b0001;  // pin0 rising
    cyc(2);
    chk("R5 level shown when enabled", int'(lvl), 1);
    drive(0, 1'b0, -1, "R1 rising ignores fall");
    drive(0, 1'b1, 0, "R1 rising");
    @(negedge clk); esel = 4'b1001;  // pin1 falling
    drive(1, 1'b1, -1, "R1 falling ignores rise");
    drive(1, 1'b0, 1, "R1 falling");
    @(negedge clk); esel = 4'b1011;  // pin0 both
    drive(0, 1'b0, 0, "R1 both fall");
    drive(0, 1'b1, 0, "R1 both rise");

    // Latency in continuous mode.
    phase = "R3";
    push(0, 1'b0, "R3 latency");
    @(negedge clk); pins[0] = 1'b0;
    cyc(2);
    chk("R3 irq not yet", int'(irq[0]), 0);
    @(negedge clk);
    chk("R3 irq on third edge", int'(irq[0]), 1);
    @(negedge clk);
    chk("R3 irq single cycle", int'(irq[0]), 0);
    drain("R3");

    // Mode routing.
    @(negedge clk); mode = 2'b00;
    drive(0, 1'b1, 2, "R4 sleep");
    @(negedge clk); mode = 2'b11;
    drive(0, 1'b0, -1, "R4 protected");
    @(negedge clk); mode = 2'b10;
    drive(0, 1'b1, 0, "R3 normal");

    // Priming after reset with the pin already high.
    phase = "R8";
    @(negedge clk); rst_n = 1'b0; esel = 4'b0001; mode = 2'b01;
    cyc(2);
    @(negedge clk); rst_n = 1'b1;
    drain("R8 no event on first sample");
    chk("R8 level primed", int'(lvl), 1);

    // Sync mode sampling.
    phase = "R6";
    @(negedge clk); esel = 4'b0011; sync = 2'b01;
    wait_fall();
    pins[0] = 1'b0;
    push(0, 1'b1, "R6 irq after window");
    wait_rise();
    chk("R6 no event before sample", q.size(), 1);
    chk("R6 level held", int'(lvl[0]), 1);
    wait_fall();
    @(negedge clk);
    chk("R6 event taken", q.size(), 0);
    chk("R6 level updated", int'(lvl[0]), 0);
    q.delete();

    // Bias timing.
    phase = "R7";
    measure("R7 short", SH);
    @(negedge clk); lng = 1'b1;
    wait_rise();
    measure("R7 long", LG);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule